// File: doc/BRIEF.md
# Branch-Resolving Program Counter

This block owns the program counter of a small processor whose instructions are all 32-bit words. Each clock it decides where execution goes next. It takes the word being executed and the two register values that word names. The word's upper field selects one of two conditional branch kinds: branch when the operands match, or branch when they differ. Every other instruction simply moves on to the following word.

When a branch condition holds, the new address is worked out from the following word, not from the branch itself. The 16-bit field in the low half of the instruction is a signed count of instructions. It is multiplied by four and added to that following address, so a branch can reach backward as well as forward. The current address, the following address, the branch destination and the branch decision are all visible at the outputs. A surrounding pipeline can use them for fetch and for debugging. An enable input freezes the counter when the pipeline stalls.

Top module: `branch_seq_unit`

## Requirements
- R1: A synchronous active-high `rst` loads `pc_q` with 0x00000000 at the next rising edge, whatever the values of `en`, `instr` and the operands.
- R2: With `en` high and `br_taken` low, `pc_q` becomes the old `pc_q` + 4 at the next edge, and `pc_q[1:0]` is always 00.
- R3: With `en` high and `br_taken` high, `pc_q` becomes `pc_q` + 4 + 4 × sign-extended `instr[15:0]` at the next edge.
- R4: Opcode `instr[31:26]` = 4 (branch-if-equal) drives `br_taken` high exactly when `opnd_a` equals `opnd_b`.
- R5: Opcode `instr[31:26]` = 5 (branch-if-not-equal) drives `br_taken` high exactly when `opnd_a` differs from `opnd_b`.
- R6: Any opcode other than 4 or 5 holds `br_taken` low and selects `pc_q` + 4, whatever the operands and the immediate field.
- R7: With `en` low, `pc_q` keeps its value across the edge, while `br_taken` still reflects the current instruction and operands.
- R8: A negative immediate moves execution backward. Immediate 0xFFFC gives a target of `pc_q` + 4 − 16.
- R9: All address arithmetic wraps modulo 2^32 with no overflow indication. Going backward from 0 gives an address near 0xFFFFFFFF, and going forward from 0xFFFFFFFC gives 0.
- R10: `pc_inc` always equals `pc_q` + 4, and `br_target` always equals `pc_q` + 4 + 4 × sign-extended `instr[15:0]`, whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low stalls the counter |
| instr | input | 32 | Instruction word at the current address |
| opnd_a | input | 32 | Value of the first register named by the instruction |
| opnd_b | input | 32 | Value of the second register named by the instruction |
| pc_q | output | 32 | Current program counter (registered) |
| pc_inc | output | 32 | Address of the following instruction |
| br_target | output | 32 | PC-relative branch destination |
| br_taken | output | 1 | Branch condition holds for the current instruction |

## Verification
A stall and a branch whose condition holds can fall in the same cycle. The bench provokes this by holding `en` low while a branch-if-equal with matching operands is presented. It then requires that `br_taken` is high before the edge and that `pc_q` is unchanged after it. Reset can also meet a taken branch during a stall. That case is driven the same way with `rst` raised, and it is judged by `pc_q` reading zero rather than the branch target.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2
  } br_kind_e;

endpackage

// File: rtl/bsu_decode.sv
module bsu_decode
  import bsu_pkg::*;
#(
  parameter int OPC_W  = 6,
  parameter int IMM_W  = 16,
  parameter int WORD_W = 30,
  parameter int OPC_EQ = 4,
  parameter int OPC_NE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [IMM_W-1:0]  imm,
  output br_kind_e          kind,
  output logic [WORD_W-1:0] off_w
);

  localparam int EXT_W = WORD_W - IMM_W;
  localparam logic [OPC_W-1:0] EQ_CODE = OPC_W'(OPC_EQ);
  localparam logic [OPC_W-1:0] NE_CODE = OPC_W'(OPC_NE);

  always_comb begin
    if (opcode == EQ_CODE) begin
      kind = BK_EQ;
    end else if (opcode == NE_CODE) begin
      kind = BK_NE;
    end else begin
      kind = BK_NONE;
    end
  end

  // Offset in words: sign-extend the immediate to the word-address width.
  generate
    if (EXT_W > 0) begin : g_ext
      assign off_w = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign off_w = imm[WORD_W-1:0];
    end
  endgenerate

  // R6: an opcode that is neither branch code decodes to no branch
  a_r6_other_none: assert property (@(posedge clk) disable iff (rst)
    (opcode != EQ_CODE && opcode != NE_CODE) |-> (kind == BK_NONE));

endmodule

// File: rtl/bsu_cond.sv
module bsu_cond
  import bsu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e          kind,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  output logic              taken
);

  logic same;

  assign same = ~|(opnd_a ^ opnd_b);

  always_comb begin
    unique case (kind)
      BK_EQ:   taken = same;
      BK_NE:   taken = ~same;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/bsu_addr.sv
module bsu_addr #(
  parameter int WORD_W = 30
) (
  input  logic [WORD_W-1:0] pc_w,
  input  logic [WORD_W-1:0] off_w,
  output logic [WORD_W-1:0] inc_w,
  output logic [WORD_W-1:0] tgt_w
);

  // Two independent adders: the increment, and the target with a carry-in of one.
  assign inc_w = pc_w + WORD_W'(1);
  assign tgt_w = pc_w + off_w + WORD_W'(1);

endmodule

// File: rtl/branch_seq_unit.sv
module branch_seq_unit
  import bsu_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          OPC_W    = 6,
  parameter int          IMM_W    = 16,
  parameter int          OPC_EQ   = 4,
  parameter int          OPC_NE   = 5,
  parameter logic [31:0] RESET_PC = 32'h0000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_inc,
  output logic [XLEN-1:0] br_target,
  output logic            br_taken
);

  localparam int WORD_W = XLEN - 2;
  localparam logic [XLEN-1:0]   RST_FULL = XLEN'(RESET_PC);
  localparam logic [WORD_W-1:0] RST_WORD = RST_FULL[XLEN-1:2];

  logic [WORD_W-1:0] pc_w;
  logic [WORD_W-1:0] off_w;
  logic [WORD_W-1:0] inc_w;
  logic [WORD_W-1:0] tgt_w;
  br_kind_e          kind;
  logic              taken;
  logic              sel_fields_unused;

  assign sel_fields_unused = ^instr[XLEN-OPC_W-1:IMM_W];

  bsu_decode #(
    .OPC_W (OPC_W),
    .IMM_W (IMM_W),
    .WORD_W(WORD_W),
    .OPC_EQ(OPC_EQ),
    .OPC_NE(OPC_NE)
  ) u_decode (
    .clk   (clk),
    .rst   (rst),
    .opcode(instr[XLEN-1:XLEN-OPC_W]),
    .imm   (instr[IMM_W-1:0]),
    .kind  (kind),
    .off_w (off_w)
  );

  bsu_cond #(
    .XLEN(XLEN)
  ) u_cond (
    .kind  (kind),
    .opnd_a(opnd_a),
    .opnd_b(opnd_b),
    .taken (taken)
  );

  bsu_addr #(
    .WORD_W(WORD_W)
  ) u_addr (
    .pc_w (pc_w),
    .off_w(off_w),
    .inc_w(inc_w),
    .tgt_w(tgt_w)
  );

  // Word-granular counter: the two byte-offset bits are constant zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_w <= RST_WORD;
    end else if (en) begin
      pc_w <= taken ? tgt_w : inc_w;
    end
  end

  assign pc_q      = {pc_w, 2'b00};
  assign pc_inc    = {inc_w, 2'b00};
  assign br_target = {tgt_w, 2'b00};
  assign br_taken  = taken;

  // R1: reset lands on the reset address
  a_r1_reset_load: assert property (@(posedge clk)
    rst |=> (pc_q == RST_FULL));

  // R2: sequential step adds four and keeps alignment
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (en && !br_taken) |=> (pc_q == $past(pc_q) + XLEN'(4)));

  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R3: taken branch lands on the presented target
  a_r3_take_target: assert property (@(posedge clk) disable iff (rst)
    (en && br_taken) |=> (pc_q == $past(br_target)));

  // R4: branch-if-equal decision at the ports
  a_r4_eq_decide: assert property (@(posedge clk) disable iff (rst)
    (instr[XLEN-1:XLEN-OPC_W] == OPC_W'(OPC_EQ)) |-> (br_taken == (opnd_a == opnd_b)));

  // R5: branch-if-not-equal decision at the ports
  a_r5_ne_decide: assert property (@(posedge clk) disable iff (rst)
    (instr[XLEN-1:XLEN-OPC_W] == OPC_W'(OPC_NE)) |-> (br_taken == (opnd_a != opnd_b)));

  // R7: stall freezes the counter
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(pc_q));

  // R10: incremented address tracks the counter
  a_r10_inc_track: assert property (@(posedge clk) disable iff (rst)
    pc_inc == pc_q + XLEN'(4));

endmodule

// File: tb/branch_seq_unit_bench.sv
module branch_seq_unit_bench;

  logic        clk;
  logic        rst;
  logic        en;
  logic [31:0] instr;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] pc_q;
  logic [31:0] pc_inc;
  logic [31:0] br_target;
  logic        br_taken;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] exp_pc;

  branch_seq_unit u_branch_seq_unit (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .instr    (instr),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .pc_q     (pc_q),
    .pc_inc   (pc_inc),
    .br_target(br_target),
    .br_taken (br_taken)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd9, 5'd10, imm};
  endfunction

  function automatic logic [31:0] tgt_of(input logic [31:0] pc, input logic [15:0] imm);
    return pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
  endfunction

  // Advance one edge, then settle away from it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; instr = mk(6'd0, 16'h0020); opnd_a = 0; opnd_b = 0;
    tick(); tick();
    chk("R1 reset pc", pc_q, 32'h0);
    rst = 1'b0;
    exp_pc = 32'h0;
  endtask

  task automatic t_sequential();
    instr = mk(6'd0, 16'h4020); opnd_a = 32'h11; opnd_b = 32'h11;
    for (int i = 0; i < 3; i++) begin
      chk("R6 no branch flag", {31'b0, br_taken}, 32'h0);
      chk("R10 pc_inc", pc_inc, exp_pc + 32'd4);
      tick();
      exp_pc = exp_pc + 32'd4;
      chk("R2 step", pc_q, exp_pc);
      chk("R2 aligned", {30'b0, pc_q[1:0]}, 32'h0);
    end
  endtask

  task automatic t_beq();
    instr = mk(6'd4, 16'd3); opnd_a = 32'hDEAD_BEEF; opnd_b = 32'hDEAD_BEEF;
    #1;
    chk("R4 equal taken", {31'b0, br_taken}, 32'h1);
    chk("R10 target", br_target, tgt_of(exp_pc, 16'd3));
    tick();
    exp_pc = tgt_of(exp_pc, 16'd3);
    chk("R3 branch landing", pc_q, exp_pc);
    opnd_b = 32'hDEAD_BEEE;
    #1;
    chk("R4 unequal not taken", {31'b0, br_taken}, 32'h0);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R4 falls through", pc_q, exp_pc);
  endtask

  task automatic t_bne();
    instr = mk(6'd5, 16'd2); opnd_a = 32'h8000_0000; opnd_b = 32'h0;
    #1;
    chk("R5 differ taken", {31'b0, br_taken}, 32'h1);
    tick();
    exp_pc = tgt_of(exp_pc, 16'd2);
    chk("R5 branch landing", pc_q, exp_pc);
    opnd_b = 32'h8000_0000;
    #1;
    chk("R5 equal not taken", {31'b0, br_taken}, 32'h0);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R5 falls through", pc_q, exp_pc);
  endtask

  task automatic t_other_opcodes();
    for (int op = 0; op < 64; op += 3) begin
      if (op != 4 && op != 5) begin
        instr = mk(6'(op), 16'h0010);
        opnd_a = 32'h5; opnd_b = (op % 2 == 0) ? 32'h5 : 32'h6;
        #1;
        chk("R6 other opcode flag", {31'b0, br_taken}, 32'h0);
        chk("R10 target shown", br_target, tgt_of(exp_pc, 16'h0010));
        tick();
        exp_pc = exp_pc + 32'd4;
        chk("R6 other opcode next", pc_q, exp_pc);
      end
    end
  endtask

  task automatic t_stall_with_branch();
    en = 1'b0;
    instr = mk(6'd4, 16'd7); opnd_a = 32'h3; opnd_b = 32'h3;
    #1;
    chk("R7 flag during stall", {31'b0, br_taken}, 32'h1);
    tick(); tick();
    chk("R7 stall hold", pc_q, exp_pc);
    en = 1'b1;
  endtask

  task automatic t_backward();
    instr = mk(6'd4, 16'hFFFC); opnd_a = 32'h0; opnd_b = 32'h0;
    #1;
    chk("R8 backward target", br_target, exp_pc + 32'd4 - 32'd16);
    tick();
    exp_pc = exp_pc + 32'd4 - 32'd16;
    chk("R8 backward landing", pc_q, exp_pc);
  endtask

  task automatic t_wrap();
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset again", pc_q, 32'h0);
    instr = mk(6'd4, 16'hFFFC); opnd_a = 32'h1; opnd_b = 32'h1;
    tick();
    chk("R9 wrap below zero", pc_q, 32'hFFFF_FFF4);
    instr = mk(6'd0, 16'h0);
    tick(); tick();
    chk("R9 top word", pc_q, 32'hFFFF_FFFC);
    chk("R9 pc_inc wraps", pc_inc, 32'h0);
    tick();
    chk("R9 wrap to zero", pc_q, 32'h0);
  endtask

  task automatic t_reset_in_stall();
    instr = mk(6'd0, 16'h0); tick(); tick();
    en = 1'b0; rst = 1'b1;
    instr = mk(6'd5, 16'd9); opnd_a = 32'h1; opnd_b = 32'h2;
    tick();
    chk("R1 reset beats stall and branch", pc_q, 32'h0);
    rst = 1'b0; en = 1'b1;
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_beq();
    t_bne();
    t_other_opcodes();
    t_stall_with_branch();
    t_backward();
    t_wrap();
    t_reset_in_stall();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule